// File: doc/BRIEF.md
# FSK Resonator Tone Generator

This block makes the sine carrier for a two-tone FSK transmitter running at an 8 kHz sample rate. A logic-one data bit selects a 1200 Hz tone and a logic-zero bit selects a 2200 Hz tone. No table of sine values is stored. Each sample comes from a two-pole recursive resonator: the next value is the tone coefficient times the latest sample, minus the sample before it. The two coefficients and the two start-up excitation values are signed fixed-point parameters fixed at elaboration.

A sample strobe at the 8 kHz rate asks for one new sample. The result shows on the output one clock later, together with a one-cycle valid pulse. When the data bit changes, only the coefficient changes and the two state registers carry on, so the waveform keeps its phase. The resonator is seeded in the first enabled cycle after reset, and again each time enable comes back after being low. A resonator whose two state registers are both zero would produce zero forever, so the seed gives it a nonzero starting impulse.

Top module: `tonegen_fsk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sample_out` is 0 and `sample_vld` is 0.
- R2: Coefficients are signed 16-bit values with 14 fraction bits. `bit_in` = 1 selects 19261 (2·cos(2π·1200/8000)) and `bit_in` = 0 selects −5126 (2·cos(2π·2200/8000)).
- R3: A new sample is x0 = sat16(((k·x1 + 8192) >>> 14) − x2). The full product is rounded to nearest with an arithmetic shift, and only one multiply is used per sample.
- R4: When a sample is produced, the older state takes the previous newer state, and the newer state takes the new sample.
- R5: The first cycle with `en` high after reset, or after a cycle with `en` low, is a seeding cycle. In that cycle the newer state is set to 0 and the older state to the excitation of the selected tone: −13255 for bit 1 and −16182 for bit 0. A strobe in a seeding cycle produces no sample, so the first sample after seeding is +13255 or +16182.
- R6: A strobe with `en` high outside a seeding cycle gives `sample_vld` = 1 and the new sample on `sample_out` on the following clock only.
- R7: In every cycle without a valid pulse, `sample_out` keeps its previous value.
- R8: While `en` is low, strobes are ignored: no valid pulse appears and `sample_out` holds.
- R9: A change of `bit_in` while enabled swaps only the coefficient. The state is not re-seeded, and the next sample is computed from the existing state.
- R10: A result outside the signed 16-bit range is clamped to 32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable; a rise re-seeds the resonator |
| bit_in | input | 1 | Data bit: 1 selects 1200 Hz, 0 selects 2200 Hz |
| strobe | input | 1 | Sample request at the 8 kHz rate |
| sample_out | output | 16 | Signed sample with 14 fraction bits |
| sample_vld | output | 1 | One-cycle pulse marking a new sample |

## Verification
The hardest case to reach is saturation. With either coefficient held steady, the resonator keeps its energy, and the seeded amplitude sits well below full scale. The clamp can only be reached by switching the coefficient at chosen phases. To get there, the bench computes the resonator energy under both coefficients before each strobe and picks the data bit that gives the larger value. The amplitude then grows until the output clamps. Constrained-random strobes, bit flips and enable drops cover the seeding and hold rules.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;

    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

endpackage

// File: rtl/tonegen_coef.sv
module tonegen_coef
    import tonegen_pkg::*;
#(
    parameter int W          = 16,
    parameter int K_MARK     = 19261,
    parameter int K_SPACE    = -5126,
    parameter int SEED_MARK  = -13255,
    parameter int SEED_SPACE = -16182
) (
    input  tone_e                sel,
    output logic signed [W-1:0]  coef,
    output logic signed [W-1:0]  seed
);

    localparam logic signed [W-1:0] KM = K_MARK[W-1:0];
    localparam logic signed [W-1:0] KS = K_SPACE[W-1:0];
    localparam logic signed [W-1:0] SM = SEED_MARK[W-1:0];
    localparam logic signed [W-1:0] SS = SEED_SPACE[W-1:0];

    always_comb begin
        if (sel == TONE_MARK) begin
            coef = KM;
            seed = SM;
        end else begin
            coef = KS;
            seed = SS;
        end
    end

endmodule

// File: rtl/tonegen_step.sv
module tonegen_step #(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic signed [W-1:0] coef,
    input  logic signed [W-1:0] x1,
    input  logic signed [W-1:0] x2,
    output logic signed [W-1:0] x0
);

    localparam int PW = 2*W + 2;
    localparam logic signed [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} <<< (FRAC-1);
    localparam logic signed [PW-1:0] MAXV = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] diff;

    always_comb begin
        prod = PW'(coef) * PW'(x1);
        rnd  = (prod + HALF) >>> FRAC;
        diff = rnd - PW'(x2);
        if (diff > MAXV) begin
            x0 = MAXV[W-1:0];
        end else if (diff < MINV) begin
            x0 = MINV[W-1:0];
        end else begin
            x0 = diff[W-1:0];
        end
    end

endmodule

// File: rtl/tonegen_fsk.sv
module tonegen_fsk
    import tonegen_pkg::*;
#(
    parameter int W          = 16,
    parameter int FRAC       = 14,
    parameter int K_MARK     = 19261,
    parameter int K_SPACE    = -5126,
    parameter int SEED_MARK  = -13255,
    parameter int SEED_SPACE = -16182
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                bit_in,
    input  logic                strobe,
    output logic signed [W-1:0] sample_out,
    output logic                sample_vld
);

    typedef struct packed {
        logic signed [W-1:0] x1;
        logic signed [W-1:0] x2;
        logic signed [W-1:0] out;
        logic                vld;
        logic                arm;
    } st_t;

    st_t st_d, st_q;

    tone_e               tone_sel;
    logic signed [W-1:0] coef_sel;
    logic signed [W-1:0] seed_sel;
    logic signed [W-1:0] x0_new;
    logic signed [W-1:0] x1_q;
    logic signed [W-1:0] x2_q;
    logic                arm_q;

    assign tone_sel = tone_e'(bit_in);

    tonegen_coef #(
        .W(W), .K_MARK(K_MARK), .K_SPACE(K_SPACE),
        .SEED_MARK(SEED_MARK), .SEED_SPACE(SEED_SPACE)
    ) u_coef (
        .sel  (tone_sel),
        .coef (coef_sel),
        .seed (seed_sel)
    );

    tonegen_step #(.W(W), .FRAC(FRAC)) u_step (
        .coef (coef_sel),
        .x1   (st_q.x1),
        .x2   (st_q.x2),
        .x0   (x0_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!en) begin
            st_d.arm = 1'b1;
        end else if (st_q.arm) begin
            st_d.x1  = '0;
            st_d.x2  = seed_sel;
            st_d.arm = 1'b0;
        end else if (strobe) begin
            st_d.x2  = st_q.x1;
            st_d.x1  = x0_new;
            st_d.out = x0_new;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.x1  <= '0;
            st_q.x2  <= '0;
            st_q.out <= '0;
            st_q.vld <= 1'b0;
            st_q.arm <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_out = st_q.out;
    assign sample_vld = st_q.vld;
    assign x1_q       = st_q.x1;
    assign x2_q       = st_q.x2;
    assign arm_q      = st_q.arm;

endmodule

// File: rtl/tonegen_fsk_chk.sv
module tonegen_fsk_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                strobe,
    input logic signed [W-1:0] sample_out,
    input logic                sample_vld,
    input logic signed [W-1:0] x1_q,
    input logic signed [W-1:0] x2_q,
    input logic signed [W-1:0] seed_sel,
    input logic                arm_q
);

    AST_VLD_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(strobe && en && !arm_q)); // R6

    AST_STROBE_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && en && !arm_q) |=> sample_vld); // R6

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> $stable(sample_out)); // R7

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && arm_q) |=> (x1_q == '0 && x2_q == $past(seed_sel))); // R5

    AST_STATE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> (x2_q == $past(x1_q) && x1_q == sample_out)); // R4

    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !sample_vld); // R8

endmodule

bind tonegen_fsk tonegen_fsk_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .strobe     (strobe),
    .sample_out (sample_out),
    .sample_vld (sample_vld),
    .x1_q       (x1_q),
    .x2_q       (x2_q),
    .seed_sel   (seed_sel),
    .arm_q      (arm_q)
);

// File: tb/tb_tonegen_fsk.sv
module tb_tonegen_fsk;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic               bit_in = 1'b0;
    logic               strobe = 1'b0;
    logic signed [15:0] sample_out;
    logic               sample_vld;

    int n_chk  = 0;
    int n_fail = 0;
    int n_cyc  = 0;
    int n_sat  = 0;
    bit done   = 1'b0;

    longint m_x1 = 0, m_x2 = 0, m_out = 0;
    bit     m_vld = 1'b0, m_arm = 1'b1;

    always #5 clk = ~clk;

    tonegen_fsk dut (
        .clk(clk), .rst_n(rst_n), .en(en), .bit_in(bit_in),
        .strobe(strobe), .sample_out(sample_out), .sample_vld(sample_vld)
    );

    // R2 coefficient and R5 excitation values
    function automatic longint kval(bit b);
        return b ? 64'sd19261 : -64'sd5126;
    endfunction

    function automatic longint seedval(bit b);
        return b ? -64'sd13255 : -64'sd16182;
    endfunction

    // R3 arithmetic with R10 clamping
    function automatic longint stepf(longint k, longint x1, longint x2, output bit sat);
        longint v;
        v   = ((k * x1 + 8192) >>> 14) - x2;
        sat = 1'b0;
        if (v > 32767)  begin v = 32767;  sat = 1'b1; end
        if (v < -32768) begin v = -32768; sat = 1'b1; end
        return v;
    endfunction

    function automatic longint energy(longint k, longint x1, longint x2);
        return x1*x1 + x2*x2 - ((k*x1*x2) >>> 14);
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // one clock: drive at negedge, update model, compare at next negedge
    task automatic cyc(bit e, bit b, bit s, string tag);
        bit sat;
        longint x0;
        @(negedge clk);
        en = e; bit_in = b; strobe = s;
        m_vld = 1'b0;
        if (!e) begin
            m_arm = 1'b1;
        end else if (m_arm) begin
            m_x1 = 0; m_x2 = seedval(b); m_arm = 1'b0;
        end else if (s) begin
            x0 = stepf(kval(b), m_x1, m_x2, sat);
            if (sat) n_sat++;
            m_x2 = m_x1; m_x1 = x0; m_out = x0; m_vld = 1'b1;
        end
        @(negedge clk);
        check({tag, " out"}, longint'(sample_out), m_out);
        check({tag, " vld"}, longint'(sample_vld), longint'(m_vld));
        en = e; bit_in = b; strobe = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            n_cyc++;
            if (n_cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <= 150000 cycles", n_cyc);
                finish_run();
            end
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check("R1 reset out", longint'(sample_out), 0);
        check("R1 reset vld", longint'(sample_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset out", longint'(sample_out), 0);
        check("R1 after reset vld", longint'(sample_vld), 0);

        // R5: strobe in seeding cycle is ignored; first mark sample is +13255
        cyc(1, 1, 1, "R5 seed cycle");
        cyc(1, 1, 1, "R2 mark");
        check("R5 first mark sample", longint'(sample_out), 13255);
        for (int i = 0; i < 20; i++) begin
            cyc(1, 1, 1, "R3 mark run");
            cyc(1, 1, 0, "R7 hold");
        end

        // R8: disabled, strobes ignored
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, "R8 disabled");

        // R5: re-seed on enable rise with space tone
        cyc(1, 0, 0, "R5 reseed");
        cyc(1, 0, 1, "R2 space");
        check("R5 first space sample", longint'(sample_out), 16182);
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, "R4 space run");

        // R9: bit flip mid-stream keeps state
        cyc(1, 1, 1, "R9 flip to mark");
        cyc(1, 0, 1, "R9 flip to space");
        cyc(1, 1, 0, "R9 flip no strobe");
        cyc(1, 1, 1, "R9 after flip");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit e, b, s;
            e = ($urandom_range(0, 31) != 0);
            b = $urandom_range(0, 1) == 1;
            s = ($urandom_range(0, 3) == 0);
            cyc(e, b, s, "R6 random");
        end

        // R10: pump energy by choosing the bit that maximizes resonator energy
        cyc(0, 1, 0, "R10 prep");
        cyc(1, 1, 0, "R10 seed");
        for (int i = 0; i < 600; i++) begin
            bit b;
            b = energy(kval(1), m_x1, m_x2) >= energy(kval(0), m_x1, m_x2);
            cyc(1, b, 1, "R10 pump");
            cyc(1, b, 0, "R10 gap");
        end
        $display("info: %0d clamped samples in model", n_sat);
        finish_run();
    end

endmodule